// File: doc/BRIEF.md
# SDRAM Command and Initialization Sequencer

This block is the command engine of a small SDRAM controller. Software writes a command word, and the block turns it into pin-level SDRAM commands on one or both chip-select banks. It holds each command for a gap taken from a packed timing word and keeps a busy flag high until a new command word can be taken. The commands are clock enable, precharge-all, a burst of auto-refreshes, mode-register load, self-refresh entry, power-down entry and return to normal mode. Software runs the power-up order itself: clock enable, at least 200 µs of waiting, precharge-all, an auto-refresh burst, the mode-register load, then normal mode.

When any bank is in normal mode, a refresh timer counts down. Each time it expires, the block issues one auto-refresh to every bank that is in normal mode. If the timer expires while a host command is running, the refresh waits until that command has finished. A command word written while the block is busy is dropped, and a sticky error flag is raised. Software clears that flag by writing the status register.

Top module: `sdr_cmd_seq`

## Requirements
- R1: After reset, all chip selects are high and RAS#/CAS#/WE# read 111. Both CKE outputs are low, and the busy bit and the error bit are both 0.
- R2: Command word bits [2:0] select the operation: 0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode register, 5 self-refresh, 6 power-down. Bit 4 selects bank 1, which drives sd_cs_n[0]. Bit 3 selects bank 2, which drives sd_cs_n[1]. A pin command asserts only the chip selects of the selected banks.
- R3: Precharge all drives RAS#/CAS#/WE# = 010 for one cycle with address bit 10 high and all other address bits low. Busy then stays high for (row-precharge field + 1) cycles.
- R4: Auto-refresh with a repeat field n in command bits [8:5] issues n+1 refresh commands (RAS#/CAS#/WE# = 001). The commands are spaced (row-cycle field + 1) cycles apart, and busy stays high for (n+1)·(row-cycle field + 1) cycles.
- R5: Load mode register drives 000 and puts command bits [21:9] on the address lines. Busy then stays high for (load-mode-to-active field + 1) cycles.
- R6: Clock enable raises CKE of the selected banks, issues no pin command and keeps busy high for one cycle.
- R7: Normal mode raises CKE of the selected banks and marks them as refreshable. It issues no pin command and keeps busy high for (exit-self-refresh field + 1) cycles.
- R8: Self-refresh drives 001 to the selected banks with their CKE going low, and keeps busy high for (active-to-precharge field + 1) cycles. Power-down lowers CKE of the selected banks with no pin command and one busy cycle. Both modes stop the periodic refresh for those banks.
- R9: The timing word holds 4-bit fields: load-mode-to-active [3:0], exit-self-refresh [7:4], active-to-precharge [11:8], row cycle [15:12], write recovery [19:16], row precharge [23:20] and row-to-column [27:24]. While any bank is in normal mode, one auto-refresh goes to all such banks every (refresh_word[13:1] + 1) cycles. Bit 0 of refresh_word is ignored.
- R10: A refresh that falls due while a host command is busy is held. It is issued on the cycle after busy has been low for one cycle. A host write in the same cycle as a due refresh goes first.
- R11: A command word written while busy is high produces no pin command and sets the sticky error bit. A write to the status register clears the error bit.
- R12: Status bit 5 reflects busy and status bit 0 reflects the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 22 | Mode, bank select, repeat count, mode-register value |
| stat_wr | input | 1 | Status write strobe, clears error |
| timing_word | input | 28 | Packed 4-bit timing fields |
| refresh_word | input | 14 | Refresh period in bits [13:1] |
| sd_cke | output | 2 | Clock enable per bank |
| sd_cs_n | output | 2 | Chip select per bank, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address lines |
| status | output | 8 | Bit 5 busy, bit 0 error |

## Verification
Precharge is sent to bank 1 alone and to bank 2 alone, which shows whether each select bit reaches the correct chip select. Auto-refresh bursts with a repeat count of 7 and of 0 separate a wrong repeat count from a wrong row-cycle spacing. A mode-register load with a distinct value shows whether its address field is shifted. The refresh period is measured with bit 0 set and then with bit 0 clear, and a long burst is made to overlap a timer expiry, so that a lost or early held refresh shows up. A write during busy and a self-refresh followed by a quiet window check that dropped commands and stopped refresh stay silent on the pins.

// File: rtl/sdr_seq_pkg.sv
// Shared encodings for the SDRAM command sequencer.
// Assumes a two-bank system with 4-bit timing fields.
package sdr_seq_pkg;
    typedef enum logic [2:0] {
        M_NORMAL = 3'd0,
        M_CKE_ON = 3'd1,
        M_PRECH  = 3'd2,
        M_AREF   = 3'd3,
        M_LOADMR = 3'd4,
        M_SELF   = 3'd5,
        M_PDOWN  = 3'd6,
        M_RSVD   = 3'd7
    } sdr_mode_e;

    // RAS#, CAS#, WE#
    typedef logic [2:0] pin_cmd_t;
    localparam pin_cmd_t PC_NOP = 3'b111;
    localparam pin_cmd_t PC_PRE = 3'b010;
    localparam pin_cmd_t PC_REF = 3'b001;
    localparam pin_cmd_t PC_LMR = 3'b000;

    localparam int NBANK  = 2;
    localparam int TF_W   = 4;
    localparam int NRF_LO = 5;
    localparam int NRF_W  = 4;
    localparam int MRV_LO = 9;

    // timing field indices
    localparam int TI_MRD = 0;
    localparam int TI_XSR = 1;
    localparam int TI_RAS = 2;
    localparam int TI_RC  = 3;
    localparam int TI_RP  = 5;
endpackage

// File: rtl/sdr_bank_state.sv
// Per-bank clock-enable and refresh-enable state.
// Updated only on an accepted host command; one copy per bank.
module sdr_bank_state
    import sdr_seq_pkg::*;
#(
    parameter int NB = NBANK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  sdr_mode_e     mode,
    input  logic [NB-1:0] sel,
    output logic [NB-1:0] cke,
    output logic [NB-1:0] norm
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        // track CKE level and normal-mode membership of bank b
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cke[b]  <= 1'b0;
                norm[b] <= 1'b0;
            end else if (upd && sel[b]) begin
                case (mode)
                    M_CKE_ON: cke[b] <= 1'b1;
                    M_NORMAL: begin
                        cke[b]  <= 1'b1;
                        norm[b] <= 1'b1;
                    end
                    M_SELF, M_PDOWN: begin
                        cke[b]  <= 1'b0;
                        norm[b] <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdr_refresh_timer.sv
// Periodic refresh request generator.
// Counts down from the reload value while enabled, raises a held
// request at zero and reloads; the request clears on acknowledge.
module sdr_refresh_timer #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] reload,
    input  logic          ack,
    output logic          pend
);
    logic [CW-1:0] cnt;

    // countdown, request set on expiry, request cleared on ack or disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (!en) begin
            cnt  <= reload;
            pend <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= reload;
            pend <= 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
            if (ack) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sdr_cmd_fsm.sv
// Command decode, gap counters, pin register and error flag.
// Host writes win over a due refresh; pins are registered and
// show NOP/deselect except in the cycle a command is issued.
module sdr_cmd_fsm
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CMD_W  = MRV_LO + ADDR_W,
    parameter int TW_W   = 7 * TF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             stat_wr,
    input  logic [TW_W-1:0]  timing_word,
    input  logic             ref_pend,
    input  logic [NBANK-1:0] norm,
    output logic             accept,
    output logic             ref_go,
    output sdr_mode_e        mode,
    output logic [NBANK-1:0] sel,
    output logic [NBANK-1:0] cs_n,
    output pin_cmd_t         pc,
    output logic [ADDR_W-1:0] addr,
    output logic             busy,
    output logic             err
);
    localparam int A10 = 10;

    logic [TF_W-1:0]  gap;
    logic [NRF_W-1:0] rep;
    logic [NBANK-1:0] rsel;

    function automatic logic [TF_W-1:0] tfield(input logic [TW_W-1:0] w, input int idx);
        return w[idx*TF_W +: TF_W];
    endfunction

    assign mode   = sdr_mode_e'(cmd_word[2:0]);
    assign sel    = {cmd_word[3], cmd_word[4]};
    assign accept = cmd_wr && !busy;
    assign ref_go = ref_pend && !busy && !cmd_wr && (|norm);

    // issue commands, run gap and repeat counters, drive busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            gap  <= '0;
            rep  <= '0;
            rsel <= '0;
            cs_n <= '1;
            pc   <= PC_NOP;
            addr <= '0;
        end else begin
            cs_n <= '1;
            pc   <= PC_NOP;
            addr <= '0;
            if (accept) begin
                busy <= 1'b1;
                rep  <= '0;
                rsel <= sel;
                gap  <= '0;
                case (mode)
                    M_PRECH: begin
                        cs_n      <= ~sel;
                        pc        <= PC_PRE;
                        addr[A10] <= 1'b1;
                        gap       <= tfield(timing_word, TI_RP);
                    end
                    M_AREF: begin
                        cs_n <= ~sel;
                        pc   <= PC_REF;
                        gap  <= tfield(timing_word, TI_RC);
                        rep  <= cmd_word[NRF_LO +: NRF_W];
                    end
                    M_LOADMR: begin
                        cs_n <= ~sel;
                        pc   <= PC_LMR;
                        addr <= cmd_word[MRV_LO +: ADDR_W];
                        gap  <= tfield(timing_word, TI_MRD);
                    end
                    M_SELF: begin
                        cs_n <= ~sel;
                        pc   <= PC_REF;
                        gap  <= tfield(timing_word, TI_RAS);
                    end
                    M_NORMAL: gap <= tfield(timing_word, TI_XSR);
                    default:  gap <= '0;
                endcase
            end else if (ref_go) begin
                busy <= 1'b1;
                rep  <= '0;
                cs_n <= ~norm;
                pc   <= PC_REF;
                gap  <= tfield(timing_word, TI_RC);
            end else if (busy) begin
                if (gap != '0) begin
                    gap <= gap - 1'b1;
                end else if (rep != '0) begin
                    rep  <= rep - 1'b1;
                    cs_n <= ~rsel;
                    pc   <= PC_REF;
                    gap  <= tfield(timing_word, TI_RC);
                end else begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // sticky error on a write during busy, cleared by a status write
    always_ff @(posedge clk) begin
        if (!rst_n)                err <= 1'b0;
        else if (cmd_wr && busy)   err <= 1'b1;
        else if (stat_wr)          err <= 1'b0;
    end
endmodule

// File: rtl/sdr_cmd_seq.sv
// Top of the SDRAM command sequencer: wires the command engine,
// the per-bank state and the refresh timer. Bank 1 is index 0.
module sdr_cmd_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int RCNT_W = 13,
    localparam int CMD_W = MRV_LO + ADDR_W,
    localparam int TW_W  = 7 * TF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              stat_wr,
    input  logic [TW_W-1:0]   timing_word,
    input  logic [RCNT_W:0]   refresh_word,
    output logic [NBANK-1:0]  sd_cke,
    output logic [NBANK-1:0]  sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [7:0]        status
);
    logic             accept, ref_go, ref_pend, busy, err;
    sdr_mode_e        mode;
    logic [NBANK-1:0] sel, norm;
    pin_cmd_t         pc;
    wire unused_fields = ^{timing_word[27:24], timing_word[19:16], refresh_word[0]};

    sdr_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk, .rst_n, .cmd_wr, .cmd_word, .stat_wr, .timing_word,
        .ref_pend, .norm, .accept, .ref_go, .mode, .sel,
        .cs_n(sd_cs_n), .pc, .addr(sd_addr), .busy, .err
    );

    sdr_bank_state #(.NB(NBANK)) u_banks (
        .clk, .rst_n, .upd(accept), .mode, .sel, .cke(sd_cke), .norm
    );

    sdr_refresh_timer #(.CW(RCNT_W)) u_rtmr (
        .clk, .rst_n, .en(|norm), .reload(refresh_word[RCNT_W:1]),
        .ack(ref_go), .pend(ref_pend)
    );

    assign {sd_ras_n, sd_cas_n, sd_we_n} = pc;
    assign status = {2'b00, busy, 4'b0000, err};
endmodule

// File: rtl/sdr_cmd_seq_chk.sv
// Port-level assertions for the SDRAM command sequencer.
module sdr_cmd_seq_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              stat_wr,
    input logic [1:0]        sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [7:0]        status
);
    // R11
    ignored_wr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && status[5]) |=> status[0]);
    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !(cmd_wr && status[5])) |=> !status[0]);
    // R2
    nop_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cs_n != 2'b11) |-> !(sd_ras_n && sd_cas_n && sd_we_n));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[5] |-> (sd_cs_n == 2'b11));
    // R3
    pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cs_n != 2'b11 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b010) |-> sd_addr[10]);
endmodule

bind sdr_cmd_seq sdr_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk, .rst_n, .cmd_wr, .stat_wr, .sd_cs_n, .sd_ras_n, .sd_cas_n,
    .sd_we_n, .sd_addr, .status
);

// File: tb/sdr_cmd_seq_tb.sv
// Scoreboard bench: the driver queues expected pin commands, the monitor
// compares every chip-select-active cycle against the queue.
module sdr_cmd_seq_tb;
    typedef struct packed {
        logic [1:0]  cs;
        logic [2:0]  pc;
        logic [12:0] addr;
    } evt_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_wr = 0;
    logic [21:0] cmd_word = '0;
    logic        stat_wr = 0;
    logic [27:0] timing_word = 28'h2315432; // rcd2 rp3 wr1 rc5 ras4 xsr3 mrd2
    logic [13:0] refresh_word = 14'd81;     // period 41, bit0 set
    logic [1:0]  sd_cke, sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic [7:0]  status;

    int   nchk = 0, nfail = 0, cyc = 0, evt_seen = 0;
    bit   sb_en = 1;
    evt_t exp_q[$];

    sdr_cmd_seq u_dut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    function automatic evt_t mk(input logic [1:0] cs, input logic [2:0] pc, input logic [12:0] a);
        evt_t e;
        e.cs = cs; e.pc = pc; e.addr = a;
        return e;
    endfunction

    // monitor: compare every active command against the queue
    always @(negedge clk) begin
        if (rst_n && sb_en && sd_cs_n != 2'b11) begin
            evt_seen++;
            if (exp_q.size() == 0) begin
                chk(0, "R2", "unexpected command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 0);
            end else begin
                evt_t e;
                e = exp_q.pop_front();
                chk(e == {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr}, "R2",
                    "pin command", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr}), int'(e));
            end
        end
    end

    task automatic issue(input logic [21:0] w, input int exp_busy, input string req);
        int n = 0;
        while (status[5]) @(negedge clk);
        cmd_word = w; cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
        while (status[5]) begin n++; @(negedge clk); end
        chk(n == exp_busy, req, "busy cycles", n, exp_busy);
        if (sb_en) chk(exp_q.size() == 0, req, "missing commands", exp_q.size(), 0);
    endtask

    task automatic wait_ref(output int t);
        @(negedge clk);
        while (!(sd_cs_n == 2'b00 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b001)) @(negedge clk);
        t = cyc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int t1, t2, t3, t4, seen0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sd_cs_n == 2'b11, "R1", "cs_n", sd_cs_n, 3);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "ras/cas/we", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
        chk(sd_cke == 2'b00 && status == 8'h00, "R1", "cke/status", {sd_cke, status}, 0);

        // R6 clock enable both banks
        issue(22'h19, 1, "R6");
        chk(sd_cke == 2'b11, "R6", "cke", sd_cke, 3);

        // R3 / R2 precharge bank 1 only, then bank 2 only
        exp_q.push_back(mk(2'b10, 3'b010, 13'h400));
        issue(22'h12, 4, "R3");
        exp_q.push_back(mk(2'b01, 3'b010, 13'h400));
        issue(22'h0A, 4, "R2");

        // R4 auto-refresh burst n=7 both, then n=0 bank 1
        for (int i = 0; i < 8; i++) exp_q.push_back(mk(2'b00, 3'b001, 13'h0));
        issue(22'hFB, 48, "R4");
        exp_q.push_back(mk(2'b10, 3'b001, 13'h0));
        issue(22'h13, 6, "R4");

        // R5 load mode register value 0x032
        exp_q.push_back(mk(2'b00, 3'b000, 13'h032));
        issue(22'h641C, 3, "R5");

        // R11 / R12 write during busy ignored, error sticky then cleared
        exp_q.push_back(mk(2'b10, 3'b010, 13'h400));
        cmd_word = 22'h12; cmd_wr = 1;
        @(negedge clk);
        chk(status[5] == 1'b1, "R12", "busy bit", status[5], 1);
        cmd_word = 22'h641C;
        @(negedge clk);
        cmd_wr = 0;
        chk(status[0] == 1'b1, "R11", "error set", status[0], 1);
        while (status[5]) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0 && status[0], "R11", "sticky error", status[0], 1);
        stat_wr = 1;
        @(negedge clk);
        stat_wr = 0;
        chk(status[0] == 1'b0, "R11", "error cleared", status[0], 0);

        // R7 normal mode, R9 refresh period and bit 0 ignored
        issue(22'h18, 4, "R7");
        chk(sd_cke == 2'b11, "R7", "cke", sd_cke, 3);
        sb_en = 0;
        wait_ref(t1);
        wait_ref(t2);
        chk(t2 - t1 == 41, "R9", "refresh period", t2 - t1, 41);
        refresh_word = 14'd80;
        wait_ref(t3);
        wait_ref(t4);
        chk(t4 - t3 == 41, "R9", "period bit0 clear", t4 - t3, 41);

        // R10 refresh held across a long host command on bank 2
        issue(22'hEB, 48, "R10");
        @(negedge clk);
        chk(sd_cs_n == 2'b00 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b001, "R10",
            "held refresh", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 1);

        // R8 self-refresh right after a timer refresh, then silence
        wait_ref(t1);
        while (status[5]) @(negedge clk);
        sb_en = 1;
        exp_q.push_back(mk(2'b00, 3'b001, 13'h0));
        issue(22'h1D, 5, "R8");
        chk(sd_cke == 2'b00, "R8", "cke after self-refresh", sd_cke, 0);
        seen0 = evt_seen;
        repeat (100) @(negedge clk);
        chk(evt_seen == seen0, "R8", "refresh stopped", evt_seen - seen0, 0);

        // R8 power-down bank 1 only
        issue(22'h19, 1, "R6");
        issue(22'h16, 1, "R8");
        chk(sd_cke == 2'b10, "R8", "cke after power-down", sd_cke, 2);

        summary();
        $finish;
    end
endmodule